// File: doc/BRIEF.md
# Shared-Memory Arbiter with Atomic Read-Modify-Write

This block lets several processors share one single-port word memory. Each master raises a request together with an opcode, an address and a write value. The arbiter chooses one requester at a time and runs its operation against the internal memory. Completion is signalled by a one-cycle done pulse to that master, with the result on a shared read-data bus. The master must keep its request, opcode, address and write value steady until it sees its done pulse, and then drop the request.

Besides plain reads and writes, two indivisible read-modify-write operations are offered: exchange and test-and-set. Both take a read cycle and then a write cycle. The grant stays with the same master across both cycles, so no other master can reach memory between the read and the write. Software builds spinlocks from these operations: a master spins on test-and-set of a lock word until it wins, works in its critical section, and frees the lock by writing 0 to the lock word with a plain write.

Top module: `abr_atomic_arbiter`

## Requirements
- R1: After reset `gnt_o` and `done_o` are all zero, and every memory word reads back as 0.
- R2: A plain read (opcode 0) of an uncontended master uses one memory cycle. `gnt_o` is high for exactly one cycle, and `done_o` pulses on the second clock edge after the request is first sampled, with `rdata_o` holding the addressed word.
- R3: A plain write (opcode 1) stores `wdata` at the address in one memory cycle, and a later read returns that value.
- R4: Exchange (opcode 2) returns the old memory word and leaves the master's `wdata` in that word.
- R5: Test-and-set (opcode 3) on a word holding 0 writes 1 to it and returns 1.
- R6: Test-and-set on a word holding a non-zero value returns 0 and leaves the word unchanged.
- R7: At most one `gnt_o` bit is high at a time. For exchange and test-and-set, the grant stays on the same master for exactly two consecutive cycles (read, then write).
- R8: Arbitration is round-robin. After master k completes, the next grant goes to the first requesting master among k+1, k+2, ... with wrap-around. After reset, master 0 has first priority.
- R9: A plain write of 0 to a lock word that test-and-set has claimed releases it, so the next test-and-set on it returns 1.
- R10: When all masters repeatedly acquire a lock with test-and-set and then increment a shared counter by read and write, the final counter equals the total number of increments, and no two masters are ever inside the critical section together.
- R11: `done_o` has at most one bit high. It pulses for one cycle, only for the master that held the grant in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N | Request, one bit per master |
| op_i | input | 2*N | Opcode per master (0 read, 1 write, 2 exchange, 3 test-and-set) |
| addr_i | input | N*AW | Word address per master |
| wdata_i | input | N*DW | Write / exchange value per master |
| gnt_o | output | N | Memory currently owned by this master |
| done_o | output | N | One-cycle completion pulse per master |
| rdata_o | output | DW | Result of the completed operation |

## Verification
The hardest case to reach from the ports is two masters racing for the same lock word: one must be between the read and write phases of its test-and-set while others keep requesting. The bench runs all four masters at once, each spinning on test-and-set and then doing a non-atomic read and write of a shared counter. Constant contention forces the round-robin to hand the bus across masters in mid-spin. A bench-side occupancy counter shows whether two masters ever hold the lock together, and the final counter value shows whether any increment was lost.

// File: rtl/abr_pkg.sv
// Shared types for the atomic bus arbiter.
// Assumes opcode encodings are fixed by the master-side software contract.
package abr_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_XCHG  = 2'd2,
        OP_TSET  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } st_e;
endpackage

// File: rtl/abr_rr_pick.sv
// Round-robin requester picker.
// Searches from the master after the last served one, with wrap-around.
// Assumes last_i < N. Purely combinational.
module abr_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          any_o,
    output logic [IW-1:0] win_o
);
    // Scan the candidates in rotating priority order
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_i) + k) % N;
            if (!any_o && req_i[idx]) begin
                any_o = 1'b1;
                win_o = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/abr_mem.sv
// Single-port word memory with combinational read and synchronous write.
// Assumes one access per cycle. Reset clears every word to zero.
module abr_mem #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    // Clear on reset, otherwise write the addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we_i) begin
            words[addr_i] <= wdata_i;
        end
    end

    // Read port
    assign rdata_o = words[addr_i];
endmodule

// File: rtl/abr_seq.sv
// Operation sequencer: owns the bus for one master at a time.
// It picks a winner when idle, runs one memory cycle for a plain access
// and two (read then write) for atomic ones. It keeps the owner fixed
// until the operation ends. Assumes the owner holds its request fields steady.
module abr_seq
    import abr_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_i,
    input  logic [IW-1:0] win_i,
    input  op_e           op_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [IW-1:0] last_o,
    output logic [IW-1:0] owner_o,
    output st_e           st_o,
    output logic          mem_we_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic [N-1:0]  gnt_o,
    output logic [N-1:0]  done_o,
    output logic [DW-1:0] rdata_o
);
    st_e           st;
    logic [IW-1:0] owner;
    logic [IW-1:0] last;
    logic [DW-1:0] old;
    logic [N-1:0]  owner_oh;
    logic          atomic;

    assign atomic   = (op_i == OP_XCHG) || (op_i == OP_TSET);
    assign owner_oh = N'(1) << owner;

    // State, ownership and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            owner   <= '0;
            last    <= IW'(N - 1);
            old     <= '0;
            done_o  <= '0;
            rdata_o <= '0;
        end else begin
            done_o <= '0;
            case (st)
                ST_IDLE: begin
                    if (any_i) begin
                        owner <= win_i;
                        st    <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (atomic) begin
                        old <= mem_rdata_i;
                        st  <= ST_SECOND;
                    end else begin
                        rdata_o <= mem_rdata_i;
                        done_o  <= owner_oh;
                        last    <= owner;
                        st      <= ST_IDLE;
                    end
                end
                ST_SECOND: begin
                    if (op_i == OP_XCHG) rdata_o <= old;
                    else                 rdata_o <= (old == '0) ? DW'(1) : '0;
                    done_o <= owner_oh;
                    last   <= owner;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Memory write strobe and value for the current phase
    always_comb begin
        mem_we_o    = 1'b0;
        mem_wdata_o = wdata_i;
        if (st == ST_FIRST && op_i == OP_WRITE) begin
            mem_we_o = 1'b1;
        end else if (st == ST_SECOND) begin
            if (op_i == OP_XCHG) begin
                mem_we_o = 1'b1;
            end else if (old == '0) begin
                mem_we_o    = 1'b1;
                mem_wdata_o = DW'(1);
            end
        end
    end

    assign gnt_o   = (st == ST_IDLE) ? '0 : owner_oh;
    assign last_o  = last;
    assign owner_o = owner;
    assign st_o    = st;
endmodule

// File: rtl/abr_atomic_arbiter.sv
// Top: N-master shared-memory arbiter with exchange and test-and-set.
// It selects the owner's request fields and drives the memory from the
// sequencer. Assumes every master holds req/op/addr/wdata until its done pulse.
module abr_atomic_arbiter
    import abr_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic [2*N-1:0]  op_i,
    input  logic [N*AW-1:0] addr_i,
    input  logic [N*DW-1:0] wdata_i,
    output logic [N-1:0]    gnt_o,
    output logic [N-1:0]    done_o,
    output logic [DW-1:0]   rdata_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic          any;
    logic [IW-1:0] win;
    logic [IW-1:0] last;
    logic [IW-1:0] owner;
    st_e           st;
    op_e           cur_op;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    // Request fields of the current owner
    assign cur_op    = op_e'(op_i[owner*2 +: 2]);
    assign cur_addr  = addr_i[owner*AW +: AW];
    assign cur_wdata = wdata_i[owner*DW +: DW];

    abr_rr_pick #(.N(N), .IW(IW)) pick_i (
        .req_i  (req_i),
        .last_i (last),
        .any_o  (any),
        .win_o  (win)
    );

    abr_seq #(.N(N), .IW(IW), .DW(DW)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_i       (any),
        .win_i       (win),
        .op_i        (cur_op),
        .wdata_i     (cur_wdata),
        .mem_rdata_i (mem_rdata),
        .last_o      (last),
        .owner_o     (owner),
        .st_o        (st),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .gnt_o       (gnt_o),
        .done_o      (done_o),
        .rdata_o     (rdata_o)
    );

    abr_mem #(.AW(AW), .DW(DW)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .addr_i  (cur_addr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );
endmodule

// File: rtl/abr_chk.sv
// Protocol checker for the atomic arbiter, attached by bind.
// Watches grants, done pulses and the sequencer phase.
module abr_chk
    import abr_pkg::*;
#(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] gnt_o,
    input logic [N-1:0] done_o,
    input st_e          st,
    input op_e          cur_op
);
    // R7
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R11
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o));

    // R11
    done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |-> (done_o == $past(gnt_o)));

    // R7
    atomic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRST && (cur_op == OP_XCHG || cur_op == OP_TSET))
        |=> (st == ST_SECOND && $stable(gnt_o)));

    // R2
    plain_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRST && (cur_op == OP_READ || cur_op == OP_WRITE))
        |=> (st == ST_IDLE && done_o != '0));
endmodule

bind abr_atomic_arbiter abr_chk #(.N(N)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .gnt_o  (gnt_o),
    .done_o (done_o),
    .st     (st),
    .cur_op (cur_op)
);

// File: tb/abr_atomic_arbiter_tb_top.sv
// Directed bench for the atomic arbiter: one task per scenario.
module abr_atomic_arbiter_tb_top;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int ITER = 6;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, XC = 2'd2, TS = 2'd3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_i;
    logic [2*N-1:0]  op_i;
    logic [N*AW-1:0] addr_i;
    logic [N*DW-1:0] wdata_i;
    logic [N-1:0]    gnt_o;
    logic [N-1:0]    done_o;
    logic [DW-1:0]   rdata_o;

    logic          m_req   [N];
    logic [1:0]    m_op    [N];
    logic [AW-1:0] m_addr  [N];
    logic [DW-1:0] m_wdata [N];

    int n_checks = 0;
    int n_fail   = 0;
    int in_cs    = 0;
    int pos      = 0;
    int order    [N];

    for (genvar g = 0; g < N; g++) begin : g_drv
        assign req_i[g]             = m_req[g];
        assign op_i[g*2 +: 2]       = m_op[g];
        assign addr_i[g*AW +: AW]   = m_addr[g];
        assign wdata_i[g*DW +: DW]  = m_wdata[g];
    end

    abr_atomic_arbiter #(.N(N), .AW(AW), .DW(DW)) dut_i (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // One operation for master m; returns result, grant cycles and latency
    task automatic do_op(input int m, input logic [1:0] op, input int a,
                         input int wd, output int rd, output int gc, output int lat);
        m_op[m] = op; m_addr[m] = AW'(a); m_wdata[m] = DW'(wd); m_req[m] = 1'b1;
        gc = 0; lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (gnt_o[m]) gc++;
        end while (!done_o[m]);
        rd = int'(rdata_o);
        m_req[m] = 1'b0;
    endtask

    task automatic t_reset();
        int rd, gc, lat;
        chk(gnt_o == '0, "R1", "gnt after reset", int'(gnt_o), 0);
        chk(done_o == '0, "R1", "done after reset", int'(done_o), 0);
        do_op(0, RD, 9, 0, rd, gc, lat);
        chk(rd == 0, "R1", "word 9 after reset", rd, 0);
    endtask

    task automatic t_plain();
        int rd, gc, lat;
        do_op(1, WR, 3, 16'hA5C3, rd, gc, lat);
        chk(gc == 1, "R3", "write grant cycles", gc, 1);
        do_op(2, RD, 3, 0, rd, gc, lat);
        chk(rd == 16'hA5C3, "R3", "read back", rd, 16'hA5C3);
        chk(gc == 1, "R2", "read grant cycles", gc, 1);
        chk(lat == 2, "R2", "read latency", lat, 2);
    endtask

    task automatic t_xchg();
        int rd, gc, lat;
        do_op(0, WR, 4, 77, rd, gc, lat);
        do_op(3, XC, 4, 1234, rd, gc, lat);
        chk(rd == 77, "R4", "exchange old value", rd, 77);
        chk(gc == 2, "R7", "exchange grant cycles", gc, 2);
        do_op(1, RD, 4, 0, rd, gc, lat);
        chk(rd == 1234, "R4", "exchange stored value", rd, 1234);
    endtask

    task automatic t_tset();
        int rd, gc, lat;
        do_op(2, TS, 6, 0, rd, gc, lat);
        chk(rd == 1, "R5", "tas on zero result", rd, 1);
        chk(gc == 2, "R7", "tas grant cycles", gc, 2);
        do_op(0, RD, 6, 0, rd, gc, lat);
        chk(rd == 1, "R5", "tas set word", rd, 1);
        do_op(0, WR, 5, 7, rd, gc, lat);
        do_op(1, TS, 5, 0, rd, gc, lat);
        chk(rd == 0, "R6", "tas on nonzero result", rd, 0);
        do_op(3, RD, 5, 0, rd, gc, lat);
        chk(rd == 7, "R6", "word unchanged", rd, 7);
    endtask

    task automatic t_release();
        int rd, gc, lat;
        do_op(0, TS, 0, 0, rd, gc, lat);
        chk(rd == 1, "R9", "first claim", rd, 1);
        do_op(1, TS, 0, 0, rd, gc, lat);
        chk(rd == 0, "R9", "claim while held", rd, 0);
        do_op(0, WR, 0, 0, rd, gc, lat);
        do_op(1, TS, 0, 0, rd, gc, lat);
        chk(rd == 1, "R9", "claim after release", rd, 1);
        do_op(1, WR, 0, 0, rd, gc, lat);
    endtask

    task automatic rr_one(input int m);
        int rd, gc, lat;
        do_op(m, RD, m, 0, rd, gc, lat);
        order[m] = pos;
        pos++;
    endtask

    task automatic t_rr();
        int rd, gc, lat;
        do_op(2, RD, 1, 0, rd, gc, lat);
        pos = 0;
        fork
            rr_one(0);
            rr_one(1);
            rr_one(2);
            rr_one(3);
        join
        chk(order[3] == 0, "R8", "slot of master 3", order[3], 0);
        chk(order[0] == 1, "R8", "slot of master 0", order[0], 1);
        chk(order[1] == 2, "R8", "slot of master 1", order[1], 2);
        chk(order[2] == 3, "R8", "slot of master 2", order[2], 3);
    endtask

    task automatic spin(input int m);
        int rd, gc, lat, c;
        for (int it = 0; it < ITER; it++) begin
            do do_op(m, TS, 0, 0, rd, gc, lat); while (rd != 1);
            in_cs++;
            chk(in_cs == 1, "R10", "critical section occupancy", in_cs, 1);
            do_op(m, RD, 1, 0, c, gc, lat);
            do_op(m, WR, 1, c + 1, rd, gc, lat);
            in_cs--;
            do_op(m, WR, 0, 0, rd, gc, lat);
        end
    endtask

    task automatic t_contend();
        int rd, gc, lat;
        do_op(0, WR, 1, 0, rd, gc, lat);
        fork
            spin(0);
            spin(1);
            spin(2);
            spin(3);
        join
        do_op(0, RD, 1, 0, rd, gc, lat);
        chk(rd == N * ITER, "R10", "final counter", rd, N * ITER);
    endtask

    // R11: done only ever one-hot and following a grant, seen at the ports
    logic [N-1:0] prev_gnt = '0;
    always @(negedge clk) begin
        if (rst_n && done_o != '0) begin
            chk(done_o == prev_gnt && $onehot(done_o), "R11", "done vs prior grant",
                int'(done_o), int'(prev_gnt));
        end
        prev_gnt <= gnt_o;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_req[i] = 1'b0; m_op[i] = RD; m_addr[i] = '0; m_wdata[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_xchg();
        t_tset();
        t_release();
        t_rr();
        t_contend();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule